// File: doc/BRIEF.md
# Multicycle Integer Processor Controller

This block is a small non-pipelined processor core for a 32-bit, three-address instruction set. A symbolic state machine takes each instruction through fetch, decode with operand read, a class-specific execute step and, where the class produces a value, a write-back into a 32-entry register file. The datapath holds a program counter, an instruction register, two operand registers (left and right), a result register and a write-back register. All memory traffic goes through one synchronous port: a read issued in one cycle returns its data in the next, and that port serves both instruction fetches and data accesses.

The states and their transitions are as follows. `ST_FETCH` issues a read at the PC and always goes to `ST_IRLOAD`. `ST_IRLOAD` captures the returned word into the instruction register, adds 4 to the PC and goes to `ST_DECODE`. `ST_DECODE` latches both operand registers from the register file and dispatches on the opcode. Register-register instructions go to `ST_EXEC_RR`. Register-immediate instructions go to `ST_EXEC_RI`. Loads and stores go to `ST_ADDR`. Both branch forms go to `ST_BRANCH`. The jump goes to `ST_JUMP` and the jump-register goes to `ST_JREG`. Any other opcode goes to `ST_HALT`. `ST_EXEC_RR` and `ST_EXEC_RI` go to `ST_WB`, which goes to `ST_WRITE`. `ST_ADDR` goes to `ST_LOAD` for a load and to `ST_STORE` for a store. `ST_LOAD` goes to `ST_LOAD_WAIT`, which goes to `ST_WRITE`. `ST_WRITE`, `ST_STORE`, `ST_BRANCH`, `ST_JUMP` and `ST_JREG` all return to `ST_FETCH`. `ST_HALT` stays in `ST_HALT` until reset.

Top module: `mc_core`

## Requirements
- R1: A synchronous reset sets the PC to 0, clears every register to zero, clears the illegal flag and enters fetch. While reset is held, the port shows a read request at address 0 and no write.
- R2: Each instruction starts with one read at the PC. In the following cycle there is no memory request, and the next instruction is fetched at the PC plus 4. A read and a write are never requested in the same cycle.
- R3: Opcode 0x00 is a register-register operation: rs is in bits 25:21, rt in bits 20:16 and rd in bits 15:11. Bits 2:0 select the operation (0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 signed set-less-than, 6 left shift, 7 logical right shift, both shifts by the low 5 bits of rt). The result goes to rd. Bits 10:3 have no effect.
- R4: Opcodes 0x08 to 0x0F are register-immediate operations. The low three opcode bits select the operation with the same numbering as R3. The right operand is bits 15:0 sign-extended, and the result goes to the register in bits 20:16.
- R5: Load (0x23) and store (0x2B) address memory at rs plus the sign-extended bits 15:0. A load writes the returned word to rt. A store writes rt to memory.
- R6: Register 0 always reads as zero, and a write aimed at it has no effect.
- R7: Opcode 0x04 branches when rs is zero and 0x05 branches when rs is non-zero. A taken branch sets the PC to the incremented PC plus the sign-extended bits 15:0 shifted left by 2. An untaken branch continues in sequence.
- R8: Jump (0x02) sets the PC to the top four bits of the incremented PC, followed by bits 25:0, followed by two zero bits. Jump-register (0x03) sets the PC to rs with its two low bits cleared. The PC stays word-aligned at all times.
- R9: Any other opcode halts the machine. The illegal flag rises and stays high, and no further memory request is made until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | XLEN | Byte address of the current memory request |
| mem_re | output | 1 | Read request; data is returned one cycle later |
| mem_we | output | 1 | Write request |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Read data for the previous cycle's request |
| illegal | output | 1 | Sticky undefined-opcode flag |

## Verification
The bench builds the core with its default width of 32 bits and 32 registers, attached to a 256-word memory model. One program runs every register-register and register-immediate operation, the write to register 0, both branch senses, the jump, the jump-register and the halting opcode. That program is repeated for six operand pairs, which reach sign and overflow edges, shift amounts beyond 31 and a zero operand that flips the data-dependent branch. A store placed after the halting opcode, together with the fetch-address trace, shows that sequencing stops where the requirements say it does.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [3:0] {
        ST_FETCH, ST_IRLOAD, ST_DECODE, ST_EXEC_RR, ST_EXEC_RI, ST_ADDR,
        ST_LOAD, ST_LOAD_WAIT, ST_STORE, ST_WB, ST_WRITE, ST_BRANCH,
        ST_JUMP, ST_JREG, ST_HALT
    } ctrl_state_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLL, ALU_SRL
    } alu_op_t;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_JREG  = 6'h03;
    localparam logic [5:0] OPC_BEQZ  = 6'h04;
    localparam logic [5:0] OPC_BNEZ  = 6'h05;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [2:0] OPC_IMM_HI = 3'b001;

    typedef struct packed {
        logic mem_re;
        logic mem_we;
        logic addr_rslt;
        logic ir_ld;
        logic opnd_ld;
        logic rslt_ld;
        logic alu_imm;
        logic alu_opc;
        logic alu_add;
        logic wb_mem;
        logic wb_rslt;
        logic rf_we;
        logic pc_branch;
        logic pc_jump;
        logic pc_jreg;
        logic halt;
    } ctrl_sig_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_t      op,
    output logic [W-1:0] y
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;
    assign shamt = b[SH_W-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL: y = a << shamt;
            ALU_SRL: y = a >> shamt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R6
    r0_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output ctrl_sig_t  cs
);
    ctrl_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FETCH:     state_nxt = ST_IRLOAD;
            ST_IRLOAD:    state_nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_REG)                              state_nxt = ST_EXEC_RR;
                else if (opcode[5:3] == OPC_IMM_HI)                 state_nxt = ST_EXEC_RI;
                else if (opcode == OPC_LOAD || opcode == OPC_STORE) state_nxt = ST_ADDR;
                else if (opcode == OPC_BEQZ || opcode == OPC_BNEZ)  state_nxt = ST_BRANCH;
                else if (opcode == OPC_JUMP)                        state_nxt = ST_JUMP;
                else if (opcode == OPC_JREG)                        state_nxt = ST_JREG;
                else                                                state_nxt = ST_HALT;
            end
            ST_EXEC_RR:   state_nxt = ST_WB;
            ST_EXEC_RI:   state_nxt = ST_WB;
            ST_ADDR:      state_nxt = (opcode == OPC_LOAD) ? ST_LOAD : ST_STORE;
            ST_LOAD:      state_nxt = ST_LOAD_WAIT;
            ST_LOAD_WAIT: state_nxt = ST_WRITE;
            ST_WB:        state_nxt = ST_WRITE;
            ST_WRITE:     state_nxt = ST_FETCH;
            ST_STORE:     state_nxt = ST_FETCH;
            ST_BRANCH:    state_nxt = ST_FETCH;
            ST_JUMP:      state_nxt = ST_FETCH;
            ST_JREG:      state_nxt = ST_FETCH;
            ST_HALT:      state_nxt = ST_HALT;
            default:      state_nxt = ST_HALT;
        endcase
    end

    always_comb begin
        cs = '0;
        unique case (state)
            ST_FETCH:     cs.mem_re = 1'b1;
            ST_IRLOAD:    cs.ir_ld = 1'b1;
            ST_DECODE:    cs.opnd_ld = 1'b1;
            ST_EXEC_RR:   cs.rslt_ld = 1'b1;
            ST_EXEC_RI: begin
                cs.rslt_ld = 1'b1;
                cs.alu_imm = 1'b1;
                cs.alu_opc = 1'b1;
            end
            ST_ADDR: begin
                cs.rslt_ld = 1'b1;
                cs.alu_imm = 1'b1;
                cs.alu_add = 1'b1;
            end
            ST_LOAD: begin
                cs.mem_re    = 1'b1;
                cs.addr_rslt = 1'b1;
            end
            ST_LOAD_WAIT: cs.wb_mem = 1'b1;
            ST_STORE: begin
                cs.mem_we    = 1'b1;
                cs.addr_rslt = 1'b1;
            end
            ST_WB:        cs.wb_rslt = 1'b1;
            ST_WRITE:     cs.rf_we = 1'b1;
            ST_BRANCH:    cs.pc_branch = 1'b1;
            ST_JUMP:      cs.pc_jump = 1'b1;
            ST_JREG:      cs.pc_jreg = 1'b1;
            ST_HALT:      cs.halt = 1'b1;
            default:      cs.halt = 1'b1;
        endcase
    end

    // R2
    fetch_then_irload_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_IRLOAD));

    // R9
    halt_is_final_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> (state == ST_HALT));
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int REG_COUNT = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_re,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            illegal
);
    localparam int RIDX_W = $clog2(REG_COUNT);

    ctrl_sig_t cs;

    logic [INSN_W-1:0] ir;
    logic [XLEN-1:0]   pc, opa, opb, rslt, wbv;
    logic [XLEN-1:0]   rf_a, rf_b, imm_sx, alu_b, alu_y;
    logic [5:0]        opcode;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
    alu_op_t           alu_op;
    logic              br_take;

    assign opcode  = ir[31:26];
    assign rs_idx  = ir[21 +: RIDX_W];
    assign rt_idx  = ir[16 +: RIDX_W];
    assign rd_idx  = ir[11 +: RIDX_W];
    assign dst_idx = (opcode == OPC_REG) ? rd_idx : rt_idx;
    assign imm_sx  = {{(XLEN-16){ir[15]}}, ir[15:0]};
    assign br_take = (opa == '0) ^ opcode[0];

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .cs     (cs)
    );

    mc_regfile #(.W(XLEN), .N(REG_COUNT)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (rs_idx),
        .ra_b (rt_idx),
        .rd_a (rf_a),
        .rd_b (rf_b),
        .we   (cs.rf_we),
        .wa   (dst_idx),
        .wd   (wbv)
    );

    always_comb begin
        if (cs.alu_add)      alu_op = ALU_ADD;
        else if (cs.alu_opc) alu_op = alu_op_t'(opcode[2:0]);
        else                 alu_op = alu_op_t'(ir[2:0]);
    end
    assign alu_b = cs.alu_imm ? imm_sx : opb;

    mc_alu #(.W(XLEN)) u_alu (
        .a  (opa),
        .b  (alu_b),
        .op (alu_op),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ir      <= '0;
            opa     <= '0;
            opb     <= '0;
            rslt    <= '0;
            wbv     <= '0;
            illegal <= 1'b0;
        end else begin
            if (cs.ir_ld) begin
                ir <= mem_rdata[INSN_W-1:0];
                pc <= pc + XLEN'(4);
            end
            if (cs.opnd_ld) begin
                opa <= rf_a;
                opb <= rf_b;
            end
            if (cs.rslt_ld) rslt <= alu_y;
            if (cs.wb_mem)       wbv <= mem_rdata;
            else if (cs.wb_rslt) wbv <= rslt;
            if (cs.pc_branch && br_take) pc <= pc + {imm_sx[XLEN-3:0], 2'b00};
            if (cs.pc_jump) pc <= {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};
            if (cs.pc_jreg) pc <= {opa[XLEN-1:2], 2'b00};
            if (cs.halt) illegal <= 1'b1;
        end
    end

    assign mem_addr  = cs.addr_rslt ? rslt : pc;
    assign mem_re    = cs.mem_re;
    assign mem_we    = cs.mem_we;
    assign mem_wdata = opb;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        cs.ir_ld |=> (pc == $past(pc) + XLEN'(4)));

    // R2
    port_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_re, mem_we}));

    // R6
    zero_source_chk: assert property (@(posedge clk) disable iff (rst)
        (cs.opnd_ld && rs_idx == '0) |=> (opa == '0));

    // R8
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (pc[1:0] == 2'b00));

    // R9
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> illegal);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_re && !mem_we));
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_re, mem_we, illegal;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] mem [256];

    int checks = 0;
    int errors = 0;

    logic [31:0] rd_log [4];
    int          rd_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .illegal   (illegal)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(negedge clk) begin
        if (rst) rd_cnt <= 0;
        else if (mem_re && rd_cnt < 4) begin
            rd_log[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [31:0] enc_r(int f, int rd, int rs, int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 8'hA5, 3'(f)};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] ref_alu(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6: return a << b[4:0];
            default: return a >> b[4:0];
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(int idx, logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 8'(idx); ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_pair(logic [31:0] a, logic [31:0] b);
        int cyc;
        rst = 1'b1;
        put(128, a);
        put(129, b);
        for (int i = 192; i < 232; i++) put(i, 32'hDEAD_BEEF);
        put(0, enc_i(6'h23, 1, 0, 16'h0200));
        put(1, enc_i(6'h23, 2, 0, 16'h0204));
        for (int k = 0; k < 8; k++) begin
            put(2 + 2*k, enc_r(k, 3, 1, 2));
            put(3 + 2*k, enc_i(6'h2B, 3, 0, 16'(16'h0300 + 4*k)));
            put(18 + 2*k, enc_i(6'(8 + k), 4, 1, 16'h8003));
            put(19 + 2*k, enc_i(6'h2B, 4, 0, 16'(16'h0340 + 4*k)));
        end
        put(34, enc_i(6'h08, 0, 1, 16'd5));
        put(35, enc_i(6'h2B, 0, 0, 16'h0380));
        put(36, enc_i(6'h04, 0, 0, 16'd1));
        put(37, enc_i(6'h08, 5, 0, 16'd1));
        put(38, enc_i(6'h05, 0, 0, 16'd1));
        put(39, enc_i(6'h08, 5, 5, 16'd2));
        put(40, enc_i(6'h2B, 5, 0, 16'h0384));
        put(41, {6'h02, 26'd43});
        put(42, enc_i(6'h08, 5, 5, 16'd16));
        put(43, enc_i(6'h08, 5, 5, 16'd4));
        put(44, enc_i(6'h08, 6, 0, 16'd188));
        put(45, enc_i(6'h03, 0, 6, 16'd0));
        put(46, enc_i(6'h08, 5, 5, 16'd32));
        put(47, enc_i(6'h2B, 5, 0, 16'h0388));
        put(48, enc_i(6'h05, 0, 1, 16'd1));
        put(49, enc_i(6'h08, 7, 0, 16'd1));
        put(50, enc_i(6'h2B, 7, 0, 16'h038C));
        put(51, 32'hFC00_0000);
        put(52, enc_i(6'h2B, 1, 0, 16'h0390));

        @(negedge clk);
        // R1: reset state at the port
        check("R1 rd req", {31'd0, mem_re}, 32'd1);
        check("R1 addr", mem_addr, 32'd0);
        check("R1 flags", {30'd0, mem_we, illegal}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2: no request in the capture cycle
        check("R2 idle", {30'd0, mem_re, mem_we}, 32'd0);
        cyc = 0;
        while (!illegal && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!illegal) check("watchdog R9", 32'd0, 32'd1);
        repeat (5) @(negedge clk);
        // R9: halted, sticky, silent
        check("R9 sticky", {31'd0, illegal}, 32'd1);
        check("R9 quiet", {30'd0, mem_re, mem_we}, 32'd0);
        check("R9 no later store", mem[228], 32'hDEAD_BEEF);
        // R2/R5: fetch at 0, load at 0x200, fetch at 4, load at 0x204
        check("R2 trace0", rd_log[0], 32'h0000_0000);
        check("R5 trace1", rd_log[1], 32'h0000_0200);
        check("R2 trace2", rd_log[2], 32'h0000_0004);
        check("R5 trace3", rd_log[3], 32'h0000_0204);
        for (int k = 0; k < 8; k++) begin
            check("R3 rr op", mem[192 + k], ref_alu(k, a, b));
            check("R4 ri op", mem[208 + k], ref_alu(k, a, 32'hFFFF_8003));
        end
        check("R6 r0 write", mem[224], 32'd0);
        check("R7 branches", mem[225], 32'd2);
        check("R8 jumps", mem[226], 32'd6);
        check("R7 data branch", mem[227], (a == 32'd0) ? 32'd1 : 32'd0);
    endtask

    initial begin
        run_pair(32'h0000_0000, 32'h0000_0000);
        run_pair(32'h0000_0001, 32'hFFFF_FFFF);
        run_pair(32'h8000_0000, 32'h0000_0001);
        run_pair(32'h1234_5678, 32'h9ABC_DEF0);
        run_pair(32'h7FFF_FFFF, 32'h8000_0000);
        run_pair(32'h0000_0005, 32'h0000_0021);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule